// File: doc/BRIEF.md
# SPI Register Slave with Latched Control Word

This block lets an external SPI master read and write a small bank of 16-bit registers. Every frame is 16 bits in SPI mode 1: the clock idles low, the slave changes MISO after a rising SCLK edge, and both sides sample on the falling edge. SCLK, MOSI, chip select and the two side-band pulse inputs are brought into the system clock domain through two-flop synchronizers. Edges of the synchronized SCLK then drive the frame shifter.

A pulse on the arm input makes the slave take its next complete frame as a control word. The control word holds three fields:
- bit 15: the read-only flag;
- bits 14:8: a 7-bit starting register offset;
- bits 7:0: an 8-bit word count.

While that control frame shifts in, the slave returns a fixed identification word on MISO. The data frames that follow visit registers in sequence, starting at the offset. After `count` frames the sequence starts again at the offset. This lets a master repeat the same transfer with no new control word. In read/write mode, each data frame returns the old contents of the addressed register and stores the received word in its place. Every store also appears on a local write port.

The write port has a valid strobe and no ready. An SPI master cannot be stalled, so the port cannot apply back-pressure. A consumer must accept one write per frame, and writes are at least 16 SCLK periods apart. A pulse on the peripheral-reset input clears every register and re-arms control capture.

Top module: `spi_ctl_slave`

## Requirements
- R1: Frames are 16 bits, MSB first. MISO changes only after a rising SCLK edge, and MOSI is sampled on the falling edge (mode 1).
- R2: After system reset, after a pulse on `io_rst`, or after a pulse on `ctl_arm`, the next complete frame is taken as a control word. During that frame MISO carries `ID_WORD` (default 16'h5A3C).
- R3: Control word fields are: bit 15 = read-only flag, bits 14:8 = starting offset, bits 7:0 = word count.
- R4: With the read-only flag set, MOSI data is ignored. No register changes and `wr_valid` stays low.
- R5: With the read-only flag clear, each data frame returns the addressed register's old value. The received word is stored there, and `wr_valid` pulses for one cycle with the register address and the received data.
- R6: The register address starts at the offset and rises by one after each data frame. After `count` data frames it returns to the offset.
- R7: The control word and the address sequence persist across chip-select transactions until a new control word is captured.
- R8: A pulse on `io_rst` clears every register to zero.
- R9: While `cs_n` is high, MISO is 0 and any partial frame is discarded.
- R10: The register used is the address modulo `NREG` (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| io_rst | input | 1 | Peripheral-reset pulse: clears the registers and re-arms control capture |
| ctl_arm | input | 1 | Pulse that makes the next frame a control word |
| sclk | input | 1 | SPI clock, idle low |
| mosi | input | 1 | SPI data from the master |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to the master |
| wr_valid | output | 1 | One-cycle strobe for a register store |
| wr_addr | output | 7 | Address of the stored register |
| wr_data | output | 16 | Stored data |

## Verification
The embedded assertions check the following on every cycle:
- no store is ever signalled under a read-only control word;
- write strobes last one cycle;
- the frame position stays below the programmed count;
- the address returns to the offset at the end of the count;
- capturing a control word disarms the slave;
- chip select high holds the bit counter at zero;
- the peripheral reset leaves the bank zero.

Only the bench's scenarios can show the following:
- the bit order and timing of mode 1, seen as the returned words;
- the identification word;
- old-value-out / new-value-in behaviour;
- persistence of the control word across transactions;
- the offset taken modulo the bank size;
- recovery after an aborted partial frame.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OFF_W  = 7;
  localparam int unsigned CNT_W  = 8;

  // Control word: read-only flag, start offset, word count
  typedef struct packed {
    logic             rd;
    logic [OFF_W-1:0] off;
    logic [CNT_W-1:0] cnt;
  } ctl_word_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         miso_bit
);
  localparam int unsigned    CW   = $clog2(W);
  localparam logic [CW-1:0]  LAST = CW'(W - 1);

  logic          sclk_d;
  logic          rise, fall;
  logic [CW-1:0] bitcnt;
  logic [W-1:0]  rx_sh, tx_sh;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      done     <= 1'b0;
      bitcnt   <= '0;
      rx_sh    <= '0;
      rx_word  <= '0;
      tx_sh    <= '0;
      miso_bit <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      done   <= 1'b0;
      if (clr) begin
        bitcnt <= '0;
      end else if (fall) begin
        rx_sh <= {rx_sh[W-2:0], mosi_s};
        if (bitcnt == LAST) begin
          bitcnt  <= '0;
          done    <= 1'b1;
          rx_word <= {rx_sh[W-2:0], mosi_s};
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
      if (load) begin
        tx_sh <= load_word;
      end else if (rise) begin
        miso_bit <= tx_sh[W-1];
        tx_sh    <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  // R9: an idle or re-armed channel restarts at bit 0
  p_clr_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bitcnt == '0));

  // R1: a frame completes at most once per falling edge
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 16,
  parameter int unsigned AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (clr)                           mem[g] <= '0;
      else if (we && waddr == AW'(g))         mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R8: after a peripheral reset every register reads zero
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rdata == '0));
endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
  import spi_ctl_pkg::*;
#(
  parameter int unsigned       NREG    = 16,
  parameter logic [WORD_W-1:0] ID_WORD = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_rst,
  input  logic              ctl_arm,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic              wr_valid,
  output logic [OFF_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int unsigned REG_AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [4:0] raw_in, sync_q;
  logic       io_s, arm_s, cs_s, mosi_s, sclk_s;
  logic       io_d, arm_d, cs_d;
  logic       io_rise, arm_rise, cs_fall;

  assign raw_in = {io_rst, ctl_arm, cs_n, mosi, sclk};
  assign {io_s, arm_s, cs_s, mosi_s, sclk_s} = sync_q;

  spi_sync #(.W(5), .RST_VAL(5'b00100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_d  <= 1'b0;
      arm_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      io_d  <= io_s;
      arm_d <= arm_s;
      cs_d  <= cs_s;
    end
  end

  assign io_rise  = io_s & ~io_d;
  assign arm_rise = arm_s & ~arm_d;
  assign cs_fall  = cs_d & ~cs_s;

  logic               done, load_q, frm_clr, miso_bit;
  logic [WORD_W-1:0]  rx_word, rdata, load_word;
  ctl_word_t          ctl, rx_ctl;
  logic               armed;
  logic [OFF_W-1:0]   ptr;
  logic [CNT_W-1:0]   idx, idx_nxt;
  logic               reg_we;

  assign rx_ctl    = ctl_word_t'(rx_word);
  assign idx_nxt   = idx + 1'b1;
  assign frm_clr   = cs_s | arm_rise | io_rise;
  assign load_word = armed ? ID_WORD : rdata;
  assign reg_we    = done & ~armed & ~ctl.rd & ~io_rise;

  spi_frame #(.W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(frm_clr), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .load(load_q), .load_word(load_word), .done(done), .rx_word(rx_word),
    .miso_bit(miso_bit)
  );

  spi_regfile #(.NREG(NREG), .W(WORD_W), .AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(io_rise), .we(reg_we),
    .waddr(ptr[REG_AW-1:0]), .wdata(rx_word),
    .raddr(ptr[REG_AW-1:0]), .rdata(rdata)
  );

  // Control and sequencing state; a count of 0 wraps after 256 frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      ctl      <= '0;
      ptr      <= '0;
      idx      <= '0;
      load_q   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      load_q   <= cs_fall | arm_rise | io_rise | done;
      if (io_rise) begin
        armed <= 1'b1;
        ctl   <= '0;
        ptr   <= '0;
        idx   <= '0;
      end else begin
        if (done) begin
          if (armed) begin
            armed <= 1'b0;
            ctl   <= rx_ctl;
            ptr   <= rx_ctl.off;
            idx   <= '0;
          end else begin
            if (!ctl.rd) begin
              wr_valid <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= rx_word;
            end
            if (idx_nxt == ctl.cnt) begin
              ptr <= ctl.off;
              idx <= '0;
            end else begin
              ptr <= ptr + 1'b1;
              idx <= idx_nxt;
            end
          end
        end
        if (arm_rise) armed <= 1'b1;
      end
    end
  end

  assign miso = cs_s ? 1'b0 : miso_bit;

  // R4: no store is reported under a read-only control word
  p_ro_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !ctl.rd);

  // R5: each store strobe lasts exactly one cycle
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R6: frame position stays inside the programmed count
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cnt != '0) |-> (idx < ctl.cnt));

  // R6: the last frame of the count sends the address back to the offset
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !armed && !io_rise && idx_nxt == ctl.cnt) |=> (ptr == $past(ctl.off)));

  // R2: a captured control word leaves the slave disarmed
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && !arm_rise && !io_rise) |=> !armed);
endmodule

// File: tb/tb_spi_ctl_slave.sv
module tb_spi_ctl_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rst = 1'b0, ctl_arm = 1'b0, sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, wr_valid;
  logic [6:0]  wr_addr;
  logic [15:0] wr_data;

  localparam logic [15:0] ID = 16'h5A3C;

  always #2.5 clk = ~clk;

  spi_ctl_slave dut (
    .clk(clk), .rst_n(rst_n), .io_rst(io_rst), .ctl_arm(ctl_arm),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_fail = 0, wr_total = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [22:0] wexp_q[$];
  string       wtag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: master samples MISO on falling SCLK
  logic [15:0] mon_sh = '0;
  int mon_cnt = 0;
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) mon_cnt = 0;
    else begin
      mon_sh = {mon_sh[14:0], miso};
      mon_cnt++;
      if (mon_cnt == 16) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected frame", 32'(mon_sh), 32'h0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(mon_sh == e, t, 32'(mon_sh), 32'(e));
        end
      end
    end
  end

  // Write-port monitor
  always @(negedge clk) begin
    if (wr_valid) begin
      wr_total++;
      if (wexp_q.size() == 0) chk(1'b0, "R4 unexpected write", 32'({wr_addr, wr_data}), 32'h0);
      else begin
        automatic logic [22:0] e = wexp_q.pop_front();
        automatic string t = wtag_q.pop_front();
        chk({wr_addr, wr_data} == e, t, 32'({wr_addr, wr_data}), 32'(e));
      end
    end
  end

  task automatic frame(input logic [15:0] mo, input logic [15:0] ex, input string tag);
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b1; mosi = mo[i]; #50;
      sclk = 1'b0; #50;
    end
  endtask

  task automatic expect_wr(input logic [6:0] a, input logic [15:0] d, input string tag);
    wexp_q.push_back({a, d});
    wtag_q.push_back(tag);
  endtask

  task automatic cs_on();  cs_n = 1'b0; #50; endtask
  task automatic cs_off(); #50; cs_n = 1'b1; #100; endtask
  task automatic arm();    ctl_arm = 1'b1; #50; ctl_arm = 1'b0; #100; endtask

  initial begin
    #500us;
    if (!finished) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #52; rst_n = 1'b1; #100;
    // Reset state: MISO low with chip select high, no writes
    chk(miso == 1'b0, "R9 reset miso idle", 32'(miso), 32'h0);
    chk(wr_valid == 1'b0, "R5 reset no write", 32'(wr_valid), 32'h0);

    // R2/R3/R5/R6: reset arms; rw, offset 3, count 4
    cs_on();
    frame(16'h0304, ID, "R2 id during control");
    for (int k = 0; k < 4; k++) begin
      expect_wr(7'(3 + k), 16'h1111 * 16'(k + 1), "R5 write port");
      frame(16'h1111 * 16'(k + 1), 16'h0000, "R5 old value out");
    end
    cs_off();

    // R7/R6: no new control word, sequence restarts at offset 3
    cs_on();
    for (int k = 0; k < 4; k++) begin
      expect_wr(7'(3 + k), 16'hA1A1 + 16'h0101 * 16'(k), "R7 write port");
      frame(16'hA1A1 + 16'h0101 * 16'(k), 16'h1111 * 16'(k + 1), "R7 R6 repeat pattern");
    end
    cs_off();
    chk(miso == 1'b0, "R9 miso idle after frame", 32'(miso), 32'h0);

    // R4/R6: read-only, offset 3, count 2, MOSI ignored, wrap after 2
    arm();
    cs_on();
    frame(16'h8302, ID, "R2 id after arm");
    frame(16'hFFFF, 16'hA1A1, "R4 R1 read reg3");
    frame(16'hFFFF, 16'hA2A2, "R4 read reg4");
    frame(16'hFFFF, 16'hA1A1, "R6 wrap to offset");
    cs_off();
    chk(wr_total == 8, "R4 no writes in read-only", 32'(wr_total), 32'd8);

    // R10/R3: offset 0x13 maps to register 3 in a 16-entry bank
    arm();
    cs_on();
    frame(16'h9301, ID, "R3 control capture");
    frame(16'h0000, 16'hA1A1, "R10 offset modulo");
    frame(16'h0000, 16'hA1A1, "R10 R6 count one");
    cs_off();

    // R9: partial frame is discarded, then a clean control word
    arm();
    cs_on();
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; mosi = 1'b1; #50; sclk = 1'b0; #50;
    end
    cs_off();
    cs_on();
    frame(16'h0001, ID, "R9 fresh control after abort");
    expect_wr(7'd0, 16'hBEEF, "R9 write reg0");
    frame(16'hBEEF, 16'h0000, "R9 reg0 old");
    expect_wr(7'd0, 16'h1234, "R5 rewrite reg0");
    frame(16'h1234, 16'hBEEF, "R5 new value visible");
    cs_off();

    // R8/R2: peripheral reset clears and re-arms without ctl_arm
    io_rst = 1'b1; #50; io_rst = 1'b0; #100;
    cs_on();
    frame(16'h8302, ID, "R2 armed after io reset");
    frame(16'h0000, 16'h0000, "R8 reg3 cleared");
    frame(16'h0000, 16'h0000, "R8 reg4 cleared");
    cs_off();
    arm();
    cs_on();
    frame(16'h8001, ID, "R2 id");
    frame(16'h0000, 16'h0000, "R8 reg0 cleared");
    cs_off();

    #200;
    chk(exp_q.size() == 0, "R1 all frames seen", 32'(exp_q.size()), 32'h0);
    chk(wexp_q.size() == 0, "R5 all writes seen", 32'(wexp_q.size()), 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule